// File: doc/BRIEF.md
# Clock Reference-Bit Victim Selector

This block chooses which page frame to give up when a new page must come in. It approximates not-recently-used replacement with a circular hand. Each frame carries a "used recently" flag and a "modified" flag. A reference port raises the used flag and, for a write, the modified flag. A request starts a sweep at the frame just after the hand. The sweep looks at one frame per clock. Each frame it passes with the used flag set loses that flag. The sweep stops at the first frame whose used flag is clear. The chosen index is returned with a one-cycle done strobe.

A request can also ask for the modified-aware policy. In that policy the sweep looks for a frame that is both unused and unmodified. If a whole revolution ends without one, it settles for the first unused frame it passed. The hand stays on the chosen frame, so the next sweep begins at the frame after it. Moving the page contents and updating any translation tables are left to the surrounding logic. The block treats the chosen frame as freshly loaded, so its modified flag is cleared.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every used and modified flag is 0, `busy` and `doneValid` are 0, and the hand rests on frame NUM_FRAMES-1, so the first sweep begins at frame 0.
- R2: A cycle with `refValid` high sets the used flag of frame `refIdx`; if `refWrite` is also high, it sets that frame's modified flag too.
- R3: A request accepted while idle raises `busy` on the next cycle. The sweep then examines one frame per cycle, starting after the hand and wrapping from NUM_FRAMES-1 to 0. When N frames are examined, `doneValid` is high for exactly one cycle, N cycles after the accepting edge, with `victimIdx` naming the chosen frame and `busy` low.
- R4: In the default policy (`dirtyMode` = 0) the victim is the first examined frame whose used flag is 0. Every frame passed over has its used flag cleared.
- R5: If every used flag is set, the sweep clears all of them in one revolution and chooses the frame it started on, after NUM_FRAMES+1 examinations.
- R6: The hand is left on the victim, so the next sweep begins at the frame after it.
- R7: With `dirtyMode` = 1 at the request, the sweep stops at the first frame that is both unused and unmodified.
- R8: With `dirtyMode` = 1, if a revolution of NUM_FRAMES examinations ends without an unused, unmodified frame, the first unused frame seen during the sweep is chosen at the end of that revolution.
- R9: A reference to the frame under examination in the same cycle keeps its used flag set, and that frame is not chosen.
- R10: `reqValid` is ignored while `busy` is high: no second sweep and no extra done strobe follow.
- R11: The chosen frame's modified flag is cleared when it is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refValid | input | 1 | A frame is being referenced this cycle |
| refIdx | input | IDX_W | Frame being referenced |
| refWrite | input | 1 | The reference is a write (marks the frame modified) |
| reqValid | input | 1 | Request a victim (taken only while idle) |
| dirtyMode | input | 1 | Policy for this request: 1 prefers unmodified frames |
| busy | output | 1 | A sweep is in progress |
| doneValid | output | 1 | One-cycle strobe: `victimIdx` is valid |
| victimIdx | output | IDX_W | Chosen frame |

## Verification
The hardest state to reach from the ports is a reference that lands in the exact cycle its frame is under the hand. The bench drives the reference port from inside the request task, counting examination cycles from the accepting edge, so the reference meets the chosen frame on its examination cycle. It then exposes the surviving flag through a later sweep whose victim and length differ depending on whether the flag survived. The modified-aware fallback needs every frame both used and modified, which a full pass of write references prepares. The two-revolution sweep that follows is then checked for its length and for the clean state of the frame it picks.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;

  // strobes from the sweep controller to the flag datapath
  typedef struct packed {
    logic start;    // load the examine index with the frame after the hand
    logic advance;  // step to the next frame, clearing the current used flag
    logic noteFb;   // remember the current frame as the fallback choice
    logic pickCur;  // choose the frame under examination
    logic pickFb;   // choose the remembered fallback frame
  } scanCmd_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scanState_t;

endpackage

// File: rtl/frame_flag_array.sv
module frame_flag_array #(
  parameter int NUM_FRAMES = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_FRAMES-1:0] setRef,
  input  logic [NUM_FRAMES-1:0] clrRef,
  input  logic [NUM_FRAMES-1:0] setDirty,
  input  logic [NUM_FRAMES-1:0] clrDirty,
  output logic [NUM_FRAMES-1:0] refBits,
  output logic [NUM_FRAMES-1:0] dirtyBits
);

  // one used/modified flag pair per frame; a set always beats a clear
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : gFrame
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        refBits[g] <= 1'b0;
      end else if (setRef[g]) begin
        refBits[g] <= 1'b1;
      end else if (clrRef[g]) begin
        refBits[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirtyBits[g] <= 1'b0;
      end else if (setDirty[g]) begin
        dirtyBits[g] <= 1'b1;
      end else if (clrDirty[g]) begin
        dirtyBits[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/clock_victim_ctrl.sv
module clock_victim_ctrl
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     dirtyMode,
  input  logic     curRef,
  input  logic     curDirty,
  input  logic     fbValid,
  output scanCmd_t cmd,
  output logic     busy
);

  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(NUM_FRAMES - 1);

  scanState_t       state;
  logic             modeDirty;
  logic [IDX_W-1:0] stepCnt;
  logic             revEnd;
  logic             cleanFree;

  assign revEnd    = (stepCnt == LAST_STEP);
  assign cleanFree = !curRef && (!modeDirty || !curDirty);
  assign busy      = (state == ST_SCAN);

  always_comb begin
    cmd = '0;
    unique case (state)
      ST_IDLE: begin
        cmd.start = reqValid;
      end
      ST_SCAN: begin
        if (cleanFree) begin
          cmd.pickCur = 1'b1;
        end else if (modeDirty && revEnd && (fbValid || !curRef)) begin
          // revolution over without a clean frame: settle for the first unused one
          if (fbValid) begin
            cmd.pickFb = 1'b1;
          end else begin
            cmd.pickCur = 1'b1;
          end
        end else begin
          cmd.advance = 1'b1;
          cmd.noteFb  = modeDirty && !curRef && !fbValid;
        end
      end
      default: cmd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      modeDirty <= 1'b0;
      stepCnt   <= '0;
    end else begin
      if (cmd.start) begin
        state     <= ST_SCAN;
        modeDirty <= dirtyMode;
        stepCnt   <= '0;
      end
      if (cmd.advance) begin
        stepCnt <= revEnd ? '0 : stepCnt + 1'b1;
      end
      if (cmd.pickCur || cmd.pickFb) begin
        state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/clock_victim_dp.sv
module clock_victim_dp
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  scanCmd_t              cmd,
  input  logic                  refValid,
  input  logic [IDX_W-1:0]      refIdx,
  input  logic                  refWrite,
  output logic                  curRef,
  output logic                  curDirty,
  output logic                  fbValid,
  output logic                  doneValid,
  output logic [IDX_W-1:0]      victimIdx,
  output logic [NUM_FRAMES-1:0] refBitsOut
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  logic [IDX_W-1:0]      handPtr;
  logic [IDX_W-1:0]      curIdx;
  logic [IDX_W-1:0]      fbIdx;
  logic [NUM_FRAMES-1:0] setRef;
  logic [NUM_FRAMES-1:0] clrRef;
  logic [NUM_FRAMES-1:0] setDirty;
  logic [NUM_FRAMES-1:0] clrDirty;
  logic [NUM_FRAMES-1:0] refBits;
  logic [NUM_FRAMES-1:0] dirtyBits;

  // per-frame decode of the reference port and of the sweep strobes
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : gDecode
    assign setRef[g]   = refValid && (refIdx == IDX_W'(g));
    assign setDirty[g] = setRef[g] && refWrite;
    assign clrRef[g]   = cmd.advance && (curIdx == IDX_W'(g));
    assign clrDirty[g] = (cmd.pickCur && (curIdx == IDX_W'(g))) ||
                         (cmd.pickFb  && (fbIdx  == IDX_W'(g)));
  end

  frame_flag_array #(.NUM_FRAMES(NUM_FRAMES)) uFlags (
    .clk      (clk),
    .rstN     (rstN),
    .setRef   (setRef),
    .clrRef   (clrRef),
    .setDirty (setDirty),
    .clrDirty (clrDirty),
    .refBits  (refBits),
    .dirtyBits(dirtyBits)
  );

  // a reference landing now counts as a use of the examined frame
  assign curRef     = refBits[curIdx] || (refValid && (refIdx == curIdx));
  assign curDirty   = dirtyBits[curIdx];
  assign refBitsOut = refBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      handPtr   <= LAST_IDX;
      curIdx    <= '0;
      fbIdx     <= '0;
      fbValid   <= 1'b0;
      victimIdx <= '0;
      doneValid <= 1'b0;
    end else begin
      doneValid <= 1'b0;
      if (cmd.start) begin
        curIdx  <= nextIdx(handPtr);
        fbValid <= 1'b0;
      end
      if (cmd.advance) begin
        curIdx <= nextIdx(curIdx);
      end
      if (cmd.noteFb) begin
        fbIdx   <= curIdx;
        fbValid <= 1'b1;
      end
      if (cmd.pickCur) begin
        handPtr   <= curIdx;
        victimIdx <= curIdx;
        doneValid <= 1'b1;
      end
      if (cmd.pickFb) begin
        handPtr   <= fbIdx;
        victimIdx <= fbIdx;
        doneValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refValid,
  input  logic [IDX_W-1:0] refIdx,
  input  logic             refWrite,
  input  logic             reqValid,
  input  logic             dirtyMode,
  output logic             busy,
  output logic             doneValid,
  output logic [IDX_W-1:0] victimIdx
);

  scanCmd_t              cmd;
  logic                  curRef;
  logic                  curDirty;
  logic                  fbValid;
  logic [NUM_FRAMES-1:0] refBits;

  clock_victim_ctrl #(.NUM_FRAMES(NUM_FRAMES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .dirtyMode(dirtyMode),
    .curRef   (curRef),
    .curDirty (curDirty),
    .fbValid  (fbValid),
    .cmd      (cmd),
    .busy     (busy)
  );

  clock_victim_dp #(.NUM_FRAMES(NUM_FRAMES)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .refValid  (refValid),
    .refIdx    (refIdx),
    .refWrite  (refWrite),
    .curRef    (curRef),
    .curDirty  (curDirty),
    .fbValid   (fbValid),
    .doneValid (doneValid),
    .victimIdx (victimIdx),
    .refBitsOut(refBits)
  );

endmodule

// File: rtl/clock_victim_chk.sv
module clock_victim_chk #(
  parameter int NUM_FRAMES = 16,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  refValid,
  input logic [IDX_W-1:0]      refIdx,
  input logic                  reqValid,
  input logic                  busy,
  input logic                  doneValid,
  input logic [IDX_W-1:0]      victimIdx,
  input logic [NUM_FRAMES-1:0] refBits
);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> ($past(busy) && !busy));

  assert_victim_unused_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !refBits[victimIdx]);

  assert_ref_sets_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    refValid |=> refBits[$past(refIdx)]);

  assert_victim_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !doneValid |-> $stable(victimIdx));

  assert_start_needs_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

endmodule

bind clock_victim_sel clock_victim_chk #(.NUM_FRAMES(NUM_FRAMES)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .refValid (refValid),
  .refIdx   (refIdx),
  .reqValid (reqValid),
  .busy     (busy),
  .doneValid(doneValid),
  .victimIdx(victimIdx),
  .refBits  (refBits)
);

// File: tb/sim_clock_victim_sel.sv
module sim_clock_victim_sel;

  localparam int NF = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          refValid = 1'b0;
  logic [IW-1:0] refIdx = '0;
  logic          refWrite = 1'b0;
  logic          reqValid = 1'b0;
  logic          dirtyMode = 1'b0;
  logic          busy;
  logic          doneValid;
  logic [IW-1:0] victimIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  clock_victim_sel #(.NUM_FRAMES(NF)) u0 (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refIdx(refIdx),
    .refWrite(refWrite), .reqValid(reqValid), .dirtyMode(dirtyMode),
    .busy(busy), .doneValid(doneValid), .victimIdx(victimIdx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; refValid = 1'b0; reqValid = 1'b0; dirtyMode = 1'b0; refWrite = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic touch(input int idx, input bit wr);
    @(negedge clk);
    refValid = 1'b1; refIdx = IW'(idx); refWrite = wr;
    @(negedge clk);
    refValid = 1'b0; refWrite = 1'b0;
  endtask

  // issue a request; optionally reference frame pokeIdx during examination
  // pokeAt, and pulse reqValid again during examination pulseAt
  task automatic request(input bit mode, input int expIdx, input int expN, input string tag,
                         input int pokeAt, input int pokeIdx, input int pulseAt);
    int cnt = 0;
    @(negedge clk);
    reqValid = 1'b1; dirtyMode = mode;
    while (cnt < 100) begin
      @(negedge clk);
      if (cnt > 0 && doneValid) break;
      if (cnt == 0) check(busy == 1'b1, {tag, " busy after accept R3"}, int'(busy), 1);
      reqValid = (pulseAt == cnt + 1);
      refValid = (pokeAt == cnt + 1);
      refIdx   = IW'(pokeIdx);
      cnt++;
    end
    reqValid = 1'b0; refValid = 1'b0;
    check(doneValid == 1'b1, {tag, " done seen R3"}, int'(doneValid), 1);
    check(int'(victimIdx) == expIdx, {tag, " victim"}, int'(victimIdx), expIdx);
    check(cnt == expN, {tag, " examined frames R3"}, cnt, expN);
    check(busy == 1'b0, {tag, " idle at done R3"}, int'(busy), 0);
    @(negedge clk);
    check(doneValid == 1'b0, {tag, " done one cycle R3"}, int'(doneValid), 0);
  endtask

  task automatic testReset();
    doReset();
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(doneValid == 1'b0, "R1 done after reset", int'(doneValid), 0);
    request(1'b0, 0, 1, "R1 first sweep starts at frame 0", 0, 0, 0);
  endtask

  task automatic testBasic();
    doReset();
    touch(0, 0); touch(1, 0); touch(2, 0);
    request(1'b0, 3, 4, "R2 R4 skip used frames", 0, 0, 0);
    request(1'b0, 4, 1, "R6 resume after hand", 0, 0, 0);
    for (int i = 5; i < NF; i++) touch(i, 0);
    request(1'b0, 0, 12, "R4 passed flags cleared wrap", 0, 0, 0);
  endtask

  task automatic testAllUsed();
    doReset();
    for (int i = 0; i < NF; i++) touch(i, 0);
    request(1'b0, 0, NF + 1, "R5 R10 all used with extra request", 0, 0, 5);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(doneValid == 1'b0, "R10 no extra done", int'(doneValid), 0);
      check(busy == 1'b0, "R10 no extra sweep", int'(busy), 0);
    end
    request(1'b0, 1, 1, "R5 revolution cleared all", 0, 0, 0);
  endtask

  task automatic testCleanPreferred();
    doReset();
    touch(0, 1); touch(1, 1); touch(2, 1);
    request(1'b0, 3, 4, "R7 setup", 0, 0, 0);
    for (int i = 4; i < NF; i++) touch(i, 0);
    request(1'b1, 3, 16, "R7 skips modified unused frames", 0, 0, 0);
  endtask

  task automatic testFallback();
    doReset();
    for (int i = 0; i < NF; i++) touch(i, 1);
    request(1'b1, 0, 2 * NF, "R8 fallback after full revolution", 0, 0, 0);
    request(1'b1, 0, NF, "R11 victim left unmodified", 0, 0, 0);
  endtask

  task automatic testSameCycleRef();
    doReset();
    touch(0, 0);
    request(1'b0, 2, 3, "R9 frame under hand referenced", 2, 1, 0);
    touch(0, 0);
    for (int i = 3; i < NF; i++) touch(i, 0);
    request(1'b0, 2, 16, "R9 flag survived the sweep", 0, 0, 0);
  endtask

  initial begin
    testReset();
    testBasic();
    testAllUsed();
    testCleanPreferred();
    testFallback();
    testSameCycleRef();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule